// File: doc/BRIEF.md
# Configurable ADC Serial Output Formatter

This block turns a stream of 14-bit parallel converter samples into a serial bit stream, one bit per clock. Before a sample is serialized it is converted to the chosen numeric format, cut to the chosen word length, put into the chosen bit order and optionally inverted. Next to the data bit it drives a bit-valid enable and a frame marker that is high over the first half of each word. Back-to-back words follow each other with no idle cycle. The data-clock enable is high for every transmitted bit.

Control comes from a byte-wide register port: an address, a data byte and a write strobe. The map is: 0x0 format (bits [1:0] format code, bit 2 invert); 0x1 serial (bits [2:0] length code, bit 3 LSB-first); 0x2 channel (bit 0 power-down, bit 1 output reset); 0x4/0x5 low/high byte of test pattern A; 0x6/0x7 low/high byte of test pattern B. Writes to any other address have no effect. A 2-bit test-select input chooses sample data (00), pattern A (01), pattern B (10) or A/B alternation (11).

A state machine sequences the serializer. OFF is entered from any state when power-down is set. HOLD is entered from LOAD or SHIFT when output reset is set, and from OFF when power-down clears while reset stays set. LOAD is entered from OFF or HOLD once both controls are clear, and it is the state after reset. SHIFT follows LOAD and stays in SHIFT while words run back to back. LOAD and the last bit of SHIFT are the word boundaries, where the sample, the test selection and all format settings are captured.

Top module: `adcser_top`

## Requirements
- R1: After reset the channel is active with 14-bit, offset-binary, MSB-first, non-inverted output, and both test patterns read as zero. Outputs stay low while reset is asserted.
- R2: Format code 01 inverts the sample MSB (twos complement). Codes 00, 10 and 11 send the sample unchanged.
- R3: Invert bit set flips every transmitted data bit.
- R4: The LSB-first bit clear sends the word MSB first. Set, it sends the word LSB first.
- R5: Length code 001 gives 8 bits, 010 gives 10, 011 gives 12, and 000 and 100 through 111 give 14.
- R6: A shorter word carries the top bits of the formatted sample; a pattern word carries the top bits of its 16-bit pattern.
- R7: The frame marker is high for the first ceil(N/2) bits of each N-bit word and low for the rest, and it is never high without the bit enable.
- R8: While active, the bit enable is high on every cycle, with no gap between words.
- R9: Register writes and test-select changes made during a word take effect only from the next word boundary.
- R10: Test patterns bypass the format conversion, but invert, bit order and length still apply.
- R11: In alternation mode successive words carry pattern A, B, A, B. The first word after output reset is released, or after alternation is selected, is pattern A.
- R12: While power-down is set, data, frame marker and bit enable are held low. On release the next word carries the current sample.
- R13: While output reset is set the serializer is idle with all outputs low. On release it starts a fresh word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| test_sel | input | 2 | 00 sample, 01 pattern A, 10 pattern B, 11 alternate |
| sample_in | input | 14 | Parallel sample, captured at word boundaries |
| ser_data | output | 1 | Serial data bit |
| frame_mark | output | 1 | Word frame marker |
| bit_en | output | 1 | Data-clock enable, high per transmitted bit |

## Verification
The alternation phase is the hardest state to reach from the ports, because the A/B toggle runs freely from whenever alternation was selected. The bench sets output reset, selects alternation, then releases the reset. This pins the first word to pattern A, and four consecutive words are then scored. Mid-word register writes are reached by locking onto a frame-marker rise and writing a new length code while that word is still shifting. The bench then counts the enabled bits of that word and of the next one.

// File: rtl/adcser_pkg.sv
`timescale 1ns/1ps
package adcser_pkg;

    typedef enum logic [1:0] {
        SEL_NORM = 2'b00,
        SEL_PATA = 2'b01,
        SEL_PATB = 2'b10,
        SEL_ALT  = 2'b11
    } tsel_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_HOLD,
        ST_LOAD,
        ST_SHIFT
    } ser_st_e;

    typedef struct packed {
        logic [1:0] fmt;
        logic       inv;
        logic [2:0] len_code;
        logic       lsb_first;
        logic       pwr_down;
        logic       out_rst;
    } ctl_s;

    localparam int ADR_FMT  = 0;
    localparam int ADR_SER  = 1;
    localparam int ADR_CHN  = 2;
    localparam int ADR_PATA = 4;

endpackage

// File: rtl/adcser_regs.sv
`timescale 1ns/1ps
module adcser_regs
    import adcser_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int PAT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctl_s              ctl,
    output logic [PAT_W-1:0]  pat_a,
    output logic [PAT_W-1:0]  pat_b
);
    localparam int HI_W = PAT_W - DATA_W;
    localparam int NPAT = 2;

    logic [PAT_W-1:0] pat_q [NPAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(ADR_FMT)) begin
                ctl.fmt <= wdata[1:0];
                ctl.inv <= wdata[2];
            end
            if (addr == ADDR_W'(ADR_SER)) begin
                ctl.len_code  <= wdata[2:0];
                ctl.lsb_first <= wdata[3];
            end
            if (addr == ADDR_W'(ADR_CHN)) begin
                ctl.pwr_down <= wdata[0];
                ctl.out_rst  <= wdata[1];
            end
        end
    end

    for (genvar g = 0; g < NPAT; g++) begin : g_pat
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pat_q[g] <= '0;
            end else if (we) begin
                if (addr == ADDR_W'(ADR_PATA + 2*g))
                    pat_q[g][DATA_W-1:0] <= wdata;
                if (addr == ADDR_W'(ADR_PATA + 2*g + 1))
                    pat_q[g][PAT_W-1:DATA_W] <= wdata[HI_W-1:0];
            end
        end
    end

    assign pat_a = pat_q[0];
    assign pat_b = pat_q[1];
endmodule

// File: rtl/adcser_word.sv
`timescale 1ns/1ps
module adcser_word
    import adcser_pkg::*;
#(
    parameter int SMP_W = 14,
    parameter int PAT_W = 16,
    parameter int LEN_W = $clog2(PAT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] sample,
    input  ctl_s             ctl,
    input  tsel_e            tsel,
    input  logic [PAT_W-1:0] pat_a,
    input  logic [PAT_W-1:0] pat_b,
    input  logic             cap,
    input  logic             quiet,
    output logic [PAT_W-1:0] nxt_word,
    output logic [LEN_W-1:0] nxt_len
);
    localparam int PAD_W = PAT_W - SMP_W;

    logic             alt_q;
    logic [SMP_W-1:0] conv;
    logic [PAT_W-1:0] src;
    logic [PAT_W-1:0] rev;
    logic [PAT_W-1:0] shr;

    // A/B phase: cleared outside alternation and while the channel is idle
    always_ff @(posedge clk) begin
        if (!rst_n || quiet || tsel != SEL_ALT)
            alt_q <= 1'b0;
        else if (cap)
            alt_q <= ~alt_q;
    end

    always_comb begin
        unique case (ctl.len_code)
            3'b001:  nxt_len = LEN_W'(8);
            3'b010:  nxt_len = LEN_W'(10);
            3'b011:  nxt_len = LEN_W'(12);
            default: nxt_len = LEN_W'(SMP_W);
        endcase
    end

    always_comb begin
        conv = sample;
        if (ctl.fmt == 2'b01)
            conv[SMP_W-1] = ~sample[SMP_W-1];
    end

    always_comb begin
        unique case (tsel)
            SEL_NORM: src = {conv, {PAD_W{1'b0}}};
            SEL_PATA: src = pat_a;
            SEL_PATB: src = pat_b;
            SEL_ALT:  src = alt_q ? pat_b : pat_a;
        endcase
    end

    // send order: bit 0 of nxt_word is transmitted first
    for (genvar g = 0; g < PAT_W; g++) begin : g_rev
        assign rev[g] = src[PAT_W-1-g];
    end

    assign shr      = src >> (LEN_W'(PAT_W) - nxt_len);
    assign nxt_word = (ctl.lsb_first ? shr : rev) ^ {PAT_W{ctl.inv}};
endmodule

// File: rtl/adcser_shift.sv
`timescale 1ns/1ps
module adcser_shift
    import adcser_pkg::*;
#(
    parameter int PAT_W = 16,
    parameter int LEN_W = $clog2(PAT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             out_rst,
    input  logic [PAT_W-1:0] nxt_word,
    input  logic [LEN_W-1:0] nxt_len,
    output logic             ser_data,
    output logic             frame_mark,
    output logic             bit_en,
    output logic             cap,
    output logic             quiet,
    output logic [LEN_W-1:0] word_len
);
    ser_st_e          state, state_nx;
    logic [PAT_W-1:0] sh_word;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] half;
    logic             last_bit;

    assign half     = (word_len + LEN_W'(1)) >> 1;
    assign last_bit = (cnt == word_len - LEN_W'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (!pwr_down) state_nx = out_rst ? ST_HOLD : ST_LOAD;
            end
            ST_HOLD: begin
                if (pwr_down)     state_nx = ST_OFF;
                else if (!out_rst) state_nx = ST_LOAD;
            end
            ST_LOAD: begin
                if (pwr_down)     state_nx = ST_OFF;
                else if (out_rst) state_nx = ST_HOLD;
                else              state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (pwr_down)     state_nx = ST_OFF;
                else if (out_rst) state_nx = ST_HOLD;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= state_nx;
    end

    assign cap = !pwr_down && !out_rst &&
                 (state == ST_LOAD || (state == ST_SHIFT && last_bit));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_word  <= '0;
            word_len <= '0;
            cnt      <= '0;
        end else if (cap) begin
            sh_word  <= nxt_word;
            word_len <= nxt_len;
            cnt      <= '0;
        end else if (state == ST_SHIFT) begin
            sh_word  <= sh_word >> 1;
            cnt      <= cnt + LEN_W'(1);
        end
    end

    always_comb begin
        bit_en     = 1'b0;
        ser_data   = 1'b0;
        frame_mark = 1'b0;
        quiet      = 1'b0;
        unique case (state)
            ST_OFF, ST_HOLD: quiet = 1'b1;
            ST_LOAD: ;
            ST_SHIFT: begin
                bit_en     = 1'b1;
                ser_data   = sh_word[0];
                frame_mark = (cnt < half);
            end
        endcase
    end
endmodule

// File: rtl/adcser_top.sv
`timescale 1ns/1ps
module adcser_top
    import adcser_pkg::*;
#(
    parameter int SMP_W  = 14,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int PAT_W  = 2 * DATA_W,
    parameter int LEN_W  = $clog2(PAT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [1:0]        test_sel,
    input  logic [SMP_W-1:0]  sample_in,
    output logic              ser_data,
    output logic              frame_mark,
    output logic              bit_en
);
    ctl_s             ctl;
    logic [PAT_W-1:0] pat_a, pat_b;
    logic [PAT_W-1:0] nxt_word;
    logic [LEN_W-1:0] nxt_len;
    logic [LEN_W-1:0] word_len;
    logic             cap, quiet;
    logic             ch_pd, ch_orst;
    tsel_e            tsel;

    assign tsel    = tsel_e'(test_sel);
    assign ch_pd   = ctl.pwr_down;
    assign ch_orst = ctl.out_rst;

    adcser_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_W(PAT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .ctl(ctl), .pat_a(pat_a), .pat_b(pat_b)
    );

    adcser_word #(.SMP_W(SMP_W), .PAT_W(PAT_W), .LEN_W(LEN_W)) u_word (
        .clk(clk), .rst_n(rst_n), .sample(sample_in), .ctl(ctl),
        .tsel(tsel), .pat_a(pat_a), .pat_b(pat_b), .cap(cap),
        .quiet(quiet), .nxt_word(nxt_word), .nxt_len(nxt_len)
    );

    adcser_shift #(.PAT_W(PAT_W), .LEN_W(LEN_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .pwr_down(ch_pd), .out_rst(ch_orst),
        .nxt_word(nxt_word), .nxt_len(nxt_len), .ser_data(ser_data),
        .frame_mark(frame_mark), .bit_en(bit_en), .cap(cap),
        .quiet(quiet), .word_len(word_len)
    );
endmodule

// File: rtl/adcser_chk.sv
`timescale 1ns/1ps
module adcser_chk #(
    parameter int LEN_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_data,
    input logic             frame_mark,
    input logic             bit_en,
    input logic             ch_pd,
    input logic             ch_orst,
    input logic [LEN_W-1:0] word_len
);
    logic [LEN_W-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          hi_cnt <= '0;
        else if (frame_mark) hi_cnt <= hi_cnt + LEN_W'(1);
        else                 hi_cnt <= '0;
    end

    a_r12_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ch_pd && $past(ch_pd) |-> !ser_data && !frame_mark && !bit_en);

    a_r13_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ch_orst && $past(ch_orst) |-> !ser_data && !frame_mark && !bit_en);

    a_r7_frame_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        frame_mark |-> bit_en);

    a_r7_half_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_mark) && bit_en |-> int'(hi_cnt) == (int'(word_len) + 1) / 2);

    a_r5_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |-> (word_len == LEN_W'(8) || word_len == LEN_W'(10) ||
                    word_len == LEN_W'(12) || word_len == LEN_W'(14)));

    a_r9_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && $past(bit_en) && !$rose(frame_mark) |-> $stable(word_len));
endmodule

bind adcser_top adcser_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .frame_mark(frame_mark),
    .bit_en(bit_en), .ch_pd(ch_pd), .ch_orst(ch_orst), .word_len(word_len)
);

// File: tb/test_adcser_top.sv
`timescale 1ns/1ps
module test_adcser_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [1:0]  test_sel = 2'b00;
    logic [13:0] sample_in = '0;
    logic        ser_data, frame_mark, bit_en;

    always #2.5 clk = ~clk;

    adcser_top i_adcser_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .test_sel(test_sel), .sample_in(sample_in),
        .ser_data(ser_data), .frame_mark(frame_mark), .bit_en(bit_en)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] bits;
        int          len;
        string       req;
    } exp_t;
    exp_t q[$];

    // bench-side view of the configuration
    logic [15:0] pa = '0, pb = '0;
    int fmt = 0, inv = 0, lsb = 0, lcode = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic int len_of(input int c);
        case (c)
            1: return 8;
            2: return 10;
            3: return 12;
            default: return 14;
        endcase
    endfunction

    function automatic logic [15:0] src_of(input int which);
        logic [13:0] s;
        s = sample_in;
        if (fmt == 1) s[13] = ~s[13];
        if (which == 1) return pa;
        if (which == 2) return pb;
        return {s, 2'b00};
    endfunction

    function automatic logic [15:0] order(input logic [15:0] src, input int n);
        logic [15:0] o;
        o = '0;
        for (int k = 0; k < 16; k++)
            if (k < n) o[k] = (lsb != 0 ? src[16-n+k] : src[15-k]) ^ (inv != 0);
        return o;
    endfunction

    task automatic push(input int which, input string req);
        exp_t e;
        e.len  = len_of(lcode);
        e.bits = order(src_of(which), e.len);
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    // monitor / scoreboard
    bit          busy = 1'b0;
    bit          pen = 1'b0, pfr = 1'b0, frerr;
    int          k;
    logic [15:0] got;
    exp_t        cur;

    task automatic drain();
        do @(negedge clk); while (q.size() != 0 || busy);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy && bit_en && frame_mark && !(pen && pfr) && q.size() != 0) begin
                cur = q.pop_front();
                busy = 1'b1; k = 0; got = '0; frerr = 1'b0;
            end
            if (busy) begin
                if (!bit_en) begin
                    chk(1'b0, cur.req, 32'(k), 32'(cur.len));
                    busy = 1'b0;
                end else begin
                    got[k] = ser_data;
                    if (frame_mark != (k < (cur.len + 1) / 2)) frerr = 1'b1;
                    k++;
                    if (k == cur.len) begin
                        chk(got == cur.bits, cur.req, 32'(got), 32'(cur.bits));
                        chk(!frerr, "R7 frame", 32'(frerr), 32'd0);
                        busy = 1'b0;
                    end
                end
            end
        end
        pen = bit_en;
        pfr = frame_mark;
    end

    task automatic quiet_run(input string req);
        int bad;
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (ser_data || frame_mark || bit_en) bad++;
        end
        chk(bad == 0, req, 32'(bad), 32'd0);
    endtask

    initial begin
        int n1, n2;
        bit pf;
        sample_in = 14'h2A5C;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!ser_data && !frame_mark && !bit_en, "R1 reset quiet",
            {29'd0, ser_data, frame_mark, bit_en}, 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        push(0, "R1 default word");
        drain();

        test_sel = 2'b01; settle();
        push(1, "R1 pattern zero");
        drain();

        // R2: twos complement and pass-through codes
        test_sel = 2'b00;
        sample_in = 14'h0123; fmt = 1; wr(0, 1); settle();
        push(0, "R2 twos"); drain();
        sample_in = 14'h3F00; fmt = 3; wr(0, 3); settle();
        push(0, "R2 code11"); drain();

        // R3: invert
        sample_in = 14'h1234; fmt = 0; inv = 1; wr(0, 4); settle();
        push(0, "R3 invert"); drain();

        // R4: LSB first
        inv = 0; wr(0, 0);
        sample_in = 14'h2001; lsb = 1; wr(1, 8); settle();
        push(0, "R4 lsb first"); drain();

        // R5 / R6: every length, both orders
        for (int o = 0; o < 2; o++) begin
            for (int c = 1; c < 8; c += 2) begin
                int cc;
                cc = (c == 5) ? 2 : c;
                sample_in = 14'h2C5B ^ 14'(cc * 37);
                lsb = o; lcode = cc;
                wr(1, (o << 3) | cc); settle();
                push(0, "R5 R6 length"); drain();
            end
        end
        sample_in = 14'h1F0F; lsb = 0; lcode = 4; wr(1, 4); settle();
        push(0, "R5 code100"); drain();

        // R8: continuous bit enable
        lcode = 0; wr(1, 0); settle();
        n1 = 0;
        repeat (40) begin
            @(negedge clk);
            if (bit_en) n1++;
        end
        chk(n1 == 40, "R8 no gap", 32'(n1), 32'd40);

        // R9: length change written mid-word
        do @(negedge clk); while (!(bit_en && frame_mark && !pfr));
        n1 = 1; n2 = 0;
        fork
            wr(1, 1);
            begin
                pf = 1'b1;
                forever begin
                    @(negedge clk);
                    if (frame_mark && !pf) break;
                    if (bit_en) n1++;
                    pf = frame_mark;
                end
                n2 = 1; pf = 1'b1;
                forever begin
                    @(negedge clk);
                    if (frame_mark && !pf) break;
                    if (bit_en) n2++;
                    pf = frame_mark;
                end
            end
        join
        chk(n1 == 14, "R9 current word", 32'(n1), 32'd14);
        chk(n2 == 8, "R9 next word", 32'(n2), 32'd8);
        lcode = 1;

        // R10: patterns bypass format, keep invert/order/length
        wr(4, 8'h5A); wr(5, 8'hC3); pa = 16'hC35A;
        wr(6, 8'hF1); wr(7, 8'h0F); pb = 16'h0FF1;
        wr(3, 8'hFF); wr(9, 8'hFF);
        fmt = 1; inv = 1; wr(0, 5);
        lsb = 1; lcode = 2; wr(1, 8'h0A);
        test_sel = 2'b01; settle();
        push(1, "R10 pattern A"); drain();
        test_sel = 2'b10; settle();
        push(2, "R10 pattern B"); drain();

        // R11: alternation from a known phase
        inv = 0; lsb = 0; lcode = 0; fmt = 0;
        wr(0, 0); wr(1, 0);
        wr(2, 2); test_sel = 2'b11; wr(2, 0); settle();
        push(1, "R11 alt 0"); push(2, "R11 alt 1");
        push(1, "R11 alt 2"); push(2, "R11 alt 3");
        drain();

        // R12: power-down
        test_sel = 2'b00;
        wr(2, 1); settle();
        quiet_run("R12 power-down");
        sample_in = 14'h0ABC; wr(2, 0); settle();
        push(0, "R12 resume"); drain();

        // R13: output reset
        wr(2, 2); settle();
        quiet_run("R13 hold");
        sample_in = 14'h3456; wr(2, 0); settle();
        push(0, "R13 restart"); drain();

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog got=%0d exp=%0d", q.size(), 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule